// File: doc/BRIEF.md
# Mode-Steered Four-Bit Arithmetic/Logic Unit with Display Gating

This block is a purely combinational arithmetic/logic unit for two unsigned 4-bit operands. A mode input chooses which unit feeds the result: the arithmetic unit or the bitwise logic unit. Inside the chosen unit, a 2-bit select code picks one of four operations. The carry from the adder and the carry from the subtractor are always brought out on separate pins. A magnitude comparator watches the operands at all times, whatever the mode.

An output stage lets the same result drive either a seven-segment digit or a row of indicator LEDs. In arithmetic mode only the digit shows anything: it displays the hexadecimal value of the result, and an overflow LED lights from the selected carry. In logic mode the digit goes dark and the LEDs show the result bits and the comparator flags.

Top module: `alu4_core`

## Requirements
- R1: With `mode`=0, `f` is the low 4 bits of: A+B when `sel`=00, A-B when `sel`=01, 0-B when `sel`=10, A+1 when `sel`=11.
- R2: `co` always equals the carry out of the 5-bit sum A+B, whatever the mode and select.
- R3: `cs` always equals the carry out of A + (bitwise NOT B) + 1. It is 1 exactly when A >= B as unsigned numbers.
- R4: With `mode`=1, `f` is bitwise A AND B for `sel`=00, A OR B for 01, A XOR B for 10, and NOT A for 11.
- R5: `eq`, `gt` and `lt` compare A with B as unsigned numbers, and exactly one of them is 1 at any time.
- R6: With `mode`=0, `seg` is the active-high hex pattern of `f`. Bit 0 is segment a and bit 6 is segment g. The digits 0..F map to 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. With `mode`=1, `seg` is all zero.
- R7: With `mode`=1, `led_res` equals `f`, and `led_cmp` is {lt, gt, eq} (bit 0 = eq). With `mode`=0, both are all zero.
- R8: With `mode`=0, `led_ovf` follows `co` for `sel`=00 and `cs` for `sel`=01, and is 0 for `sel`=10 or 11. With `mode`=1, `led_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| mode | input | 1 | 0 = arithmetic, 1 = logic |
| sel | input | 2 | Operation select within the mode |
| f | output | 4 | Selected result |
| co | output | 1 | Carry out of A+B |
| cs | output | 1 | Carry out of A-B (no-borrow) |
| eq | output | 1 | A equals B |
| gt | output | 1 | A greater than B |
| lt | output | 1 | A less than B |
| seg | output | 7 | Seven-segment pattern, a at bit 0 |
| led_res | output | 4 | Result LEDs, lit in logic mode only |
| led_cmp | output | 3 | Comparator LEDs {lt,gt,eq}, logic mode only |
| led_ovf | output | 1 | Overflow LED, arithmetic mode only |

## Verification
The assertions check on every input change that the comparator flags stay one-hot and that `cs` agrees with the unsigned ordering. They also check that the digit is dark in logic mode, that the LEDs are dark in arithmetic mode, and that the overflow LED is zero for select codes 10 and 11. In addition they check that negation cancels B and that an addition carry coincides with a wrapped sum. The exact result values for each opcode, the full segment table and how the overflow LED follows each carry can only be shown by the bench's scenarios. These scenarios compare many random and corner operand pairs against independently computed values.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int OPW = 4;
    localparam int SEGW = 7;

    typedef enum logic [1:0] {
        ARI_ADD = 2'b00,
        ARI_SUB = 2'b01,
        ARI_NEG = 2'b10,
        ARI_INC = 2'b11
    } arith_op_e;

    typedef enum logic [1:0] {
        LOG_AND  = 2'b00,
        LOG_OR   = 2'b01,
        LOG_XOR  = 2'b10,
        LOG_NOTA = 2'b11
    } logic_op_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } cmp_flags_t;

    typedef struct packed {
        logic add_c;
        logic sub_c;
    } carry_pair_t;

    function automatic logic [SEGW-1:0] hex_to_seg(input logic [3:0] v);
        logic [SEGW-1:0] p;
        case (v)
            4'h0: p = 7'h3F;
            4'h1: p = 7'h06;
            4'h2: p = 7'h5B;
            4'h3: p = 7'h4F;
            4'h4: p = 7'h66;
            4'h5: p = 7'h6D;
            4'h6: p = 7'h7D;
            4'h7: p = 7'h07;
            4'h8: p = 7'h7F;
            4'h9: p = 7'h6F;
            4'hA: p = 7'h77;
            4'hB: p = 7'h7C;
            4'hC: p = 7'h39;
            4'hD: p = 7'h5E;
            4'hE: p = 7'h79;
            default: p = 7'h71;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/alu4_arith.sv
module alu4_arith
    import alu4_pkg::*;
#(
    parameter int WIDTH = OPW
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] f,
    output carry_pair_t      carries
);
    localparam int EXT = WIDTH + 1;
    localparam logic [EXT-1:0] ONE_EXT = EXT'(1);
    localparam int NCH = 4;

    logic [EXT-1:0] sum_w, dif_w, neg_w, inc_w;
    logic [WIDTH-1:0] chan [NCH];

    // Shared widened operands
    logic [EXT-1:0] a_ext, b_ext, bn_ext;
    assign a_ext  = {1'b0, a};
    assign b_ext  = {1'b0, b};
    assign bn_ext = {1'b0, ~b};

    assign sum_w = a_ext + b_ext;
    assign dif_w = a_ext + bn_ext + ONE_EXT;
    assign neg_w = bn_ext + ONE_EXT;
    assign inc_w = a_ext + ONE_EXT;

    assign chan[ARI_ADD] = sum_w[WIDTH-1:0];
    assign chan[ARI_SUB] = dif_w[WIDTH-1:0];
    assign chan[ARI_NEG] = neg_w[WIDTH-1:0];
    assign chan[ARI_INC] = inc_w[WIDTH-1:0];

    logic unused_hi;
    assign unused_hi = neg_w[WIDTH] ^ inc_w[WIDTH];

    assign f = chan[sel];
    assign carries.add_c = sum_w[WIDTH];
    assign carries.sub_c = dif_w[WIDTH];
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
    import alu4_pkg::*;
#(
    parameter int WIDTH = OPW
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] f
);
    localparam int NCH = 4;
    logic [WIDTH-1:0] chan [NCH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign chan[LOG_AND][i]  = a[i] & b[i];
        assign chan[LOG_OR][i]   = a[i] | b[i];
        assign chan[LOG_XOR][i]  = a[i] ^ b[i];
        assign chan[LOG_NOTA][i] = ~a[i];
    end

    assign f = chan[sel];
endmodule

// File: rtl/alu4_cmp.sv
module alu4_cmp
    import alu4_pkg::*;
#(
    parameter int WIDTH = OPW
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output cmp_flags_t       flags
);
    always_comb begin
        flags.eq = (a == b);
        flags.gt = (a > b);
        flags.lt = ~flags.eq & ~flags.gt;
    end
endmodule

// File: rtl/alu4_display.sv
module alu4_display
    import alu4_pkg::*;
#(
    parameter int WIDTH = OPW
) (
    input  logic             mode,
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] f,
    input  cmp_flags_t       flags,
    input  carry_pair_t      carries,
    output logic [SEGW-1:0]  seg,
    output logic [WIDTH-1:0] led_res,
    output logic [2:0]       led_cmp,
    output logic             led_ovf
);
    logic arith_on;
    assign arith_on = ~mode;

    always_comb begin
        seg     = '0;
        led_res = '0;
        led_cmp = '0;
        led_ovf = 1'b0;
        if (arith_on) begin
            seg = hex_to_seg(f[3:0]);
            case (arith_op_e'(sel))
                ARI_ADD: led_ovf = carries.add_c;
                ARI_SUB: led_ovf = carries.sub_c;
                default: led_ovf = 1'b0;
            endcase
        end else begin
            led_res = f;
            led_cmp = flags;
        end
    end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int WIDTH = OPW
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             mode,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] f,
    output logic             co,
    output logic             cs,
    output logic             eq,
    output logic             gt,
    output logic             lt,
    output logic [SEGW-1:0]  seg,
    output logic [WIDTH-1:0] led_res,
    output logic [2:0]       led_cmp,
    output logic             led_ovf
);
    logic [WIDTH-1:0] arith_f, logic_f;
    carry_pair_t      carries;
    cmp_flags_t       flags;

    alu4_arith #(.WIDTH(WIDTH)) u_arith (
        .a(a), .b(b), .sel(sel), .f(arith_f), .carries(carries)
    );

    alu4_logic #(.WIDTH(WIDTH)) u_logic (
        .a(a), .b(b), .sel(sel), .f(logic_f)
    );

    alu4_cmp #(.WIDTH(WIDTH)) u_cmp (
        .a(a), .b(b), .flags(flags)
    );

    // Two-channel result mux steered by mode
    assign f  = mode ? logic_f : arith_f;
    assign co = carries.add_c;
    assign cs = carries.sub_c;
    assign eq = flags.eq;
    assign gt = flags.gt;
    assign lt = flags.lt;

    alu4_display #(.WIDTH(WIDTH)) u_disp (
        .mode(mode), .sel(sel), .f(f), .flags(flags), .carries(carries),
        .seg(seg), .led_res(led_res), .led_cmp(led_cmp), .led_ovf(led_ovf)
    );
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             mode,
    input logic [1:0]       sel,
    input logic [WIDTH-1:0] f,
    input logic             co,
    input logic             cs,
    input logic             eq,
    input logic             gt,
    input logic             lt,
    input logic [6:0]       seg,
    input logic [WIDTH-1:0] led_res,
    input logic [2:0]       led_cmp,
    input logic             led_ovf
);
    always_comb begin
        assert_cmp_onehot_R5: assert ($onehot({eq, gt, lt}))
            else $error("comparator flags not one-hot");
        assert_cs_order_R3: assert (cs == (a >= b))
            else $error("cs disagrees with operand order");
        if (mode) begin
            assert_seg_dark_R6: assert (seg == '0)
                else $error("digit lit in logic mode");
            assert_ovf_dark_R8: assert (!led_ovf)
                else $error("overflow LED lit in logic mode");
        end else begin
            assert_led_dark_R7: assert (led_res == '0 && led_cmp == '0)
                else $error("LEDs lit in arithmetic mode");
            if (sel[1]) begin
                assert_ovf_zero_R8: assert (!led_ovf)
                    else $error("overflow LED for non-add/sub code");
            end
            if (sel == 2'b10) begin
                assert_neg_cancel_R1: assert (WIDTH'(f + b) == '0)
                    else $error("negation does not cancel B");
            end
            if (sel == 2'b00) begin
                assert_add_wrap_R2: assert (co == (f < a))
                    else $error("addition carry disagrees with wrap");
            end
        end
    end
endmodule

bind alu4_core alu4_core_chk #(.WIDTH(WIDTH)) u_chk (
    .a(a), .b(b), .mode(mode), .sel(sel), .f(f), .co(co), .cs(cs),
    .eq(eq), .gt(gt), .lt(lt), .seg(seg), .led_res(led_res),
    .led_cmp(led_cmp), .led_ovf(led_ovf)
);

// File: tb/alu4_core_test.sv
module alu4_core_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [3:0] a, b, f, led_res;
    logic       mode, co, cs, eq, gt, lt, led_ovf;
    logic [1:0] sel;
    logic [6:0] seg;
    logic [2:0] led_cmp;

    int runs = 0;
    int fails = 0;
    bit done = 0;

    alu4_core uut (
        .a(a), .b(b), .mode(mode), .sel(sel), .f(f), .co(co), .cs(cs),
        .eq(eq), .gt(gt), .lt(lt), .seg(seg), .led_res(led_res),
        .led_cmp(led_cmp), .led_ovf(led_ovf)
    );

    function automatic logic [6:0] exp_seg(input logic [3:0] v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v];
    endfunction

    function automatic logic [3:0] exp_f(input logic [3:0] x, input logic [3:0] y,
                                          input logic m, input logic [1:0] s);
        int r;
        if (!m) begin
            case (s)
                2'b00: r = x + y;
                2'b01: r = x - y;
                2'b10: r = 0 - y;
                default: r = x + 1;
            endcase
            return r[3:0];
        end
        case (s)
            2'b00: return x & y;
            2'b01: return x | y;
            2'b10: return x ^ y;
            default: return ~x;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        runs++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s a=%h b=%h mode=%b sel=%b actual=%h expected=%h",
                     tag, a, b, mode, sel, act, expv);
        end
    endtask

    task automatic apply(input logic [3:0] x, input logic [3:0] y,
                         input logic m, input logic [1:0] s);
        logic [3:0] ef;
        logic       eco, ecs, eovf;
        @(negedge clk);
        a = x; b = y; mode = m; sel = s;
        #2;
        ef   = exp_f(x, y, m, s);
        eco  = (int'(x) + int'(y)) > 15;
        ecs  = (x >= y);
        eovf = !m && ((s == 2'b00) ? eco : (s == 2'b01) ? ecs : 1'b0);
        check(m ? "R4 logic result" : "R1 arith result", {4'h0, f}, {4'h0, ef});
        check("R2 add carry", {7'h0, co}, {7'h0, eco});
        check("R3 sub carry", {7'h0, cs}, {7'h0, ecs});
        check("R5 compare", {5'h0, lt, gt, eq}, {5'h0, x < y, x > y, x == y});
        check("R6 segments", {1'b0, seg}, m ? 8'h00 : {1'b0, exp_seg(ef)});
        check("R7 result leds", {4'h0, led_res}, m ? {4'h0, ef} : 8'h00);
        check("R7 compare leds", {5'h0, led_cmp}, m ? {5'h0, x < y, x > y, x == y} : 8'h00);
        check("R8 overflow led", {7'h0, led_ovf}, {7'h0, eovf});
    endtask

    initial begin
        a = '0; b = '0; mode = 1'b0; sel = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-time state: all-zero inputs, add mode
        #1;
        check("R6 initial digit shows 0", {1'b0, seg}, 8'h3F);
        check("R5 initial equal", {5'h0, lt, gt, eq}, 8'h01);
        // directed corners
        apply(4'hF, 4'h1, 1'b0, 2'b00);   // R2 carry wrap
        apply(4'h8, 4'h8, 1'b0, 2'b00);
        apply(4'h3, 4'h5, 1'b0, 2'b01);   // R3 borrow
        apply(4'h5, 4'h5, 1'b0, 2'b01);   // R3 equal operands
        apply(4'h0, 4'h0, 1'b0, 2'b10);   // R1 negate zero
        apply(4'h7, 4'h8, 1'b0, 2'b10);
        apply(4'hF, 4'h0, 1'b0, 2'b11);   // R1 increment wrap
        apply(4'hA, 4'h6, 1'b1, 2'b00);
        apply(4'hA, 4'h6, 1'b1, 2'b01);
        apply(4'hF, 4'hF, 1'b1, 2'b10);
        apply(4'h0, 4'h9, 1'b1, 2'b11);
        for (int v = 0; v < 16; v++) apply(4'(v), 4'h0, 1'b1, 2'b11);
        for (int v = 0; v < 16; v++) apply(4'(v), 4'h0, 1'b0, 2'b00); // R6 all digits
        // constrained random
        void'($urandom(32'd20240611));
        for (int k = 0; k < 600; k++)
            apply(4'($urandom), 4'($urandom), 1'($urandom), 2'($urandom));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            runs++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule